// File: doc/BRIEF.md
# Vector Element Extract Unit

This unit reads one element out of a single vector register and returns it as a value as wide as a scalar register. The caller presents the whole register as one flat bus, a 2-bit code for the element width in force, an unsigned element index taken from a scalar register, and a request strobe. Exactly one clock later the unit presents the scalar result with a valid flag.

The element width can be 8, 16, 32 or 64 bits and is chosen at run time. Elements are packed from the least-significant end of the register. When the index names an element past the end of the register for the chosen width, the result is zero. It does not wrap. A narrow element is zero-extended to the scalar width. An element wider than the scalar keeps only its low bits. Register grouping plays no part: only the one register supplied is read. A zero index, as the hard-wired zero register gives it, reads the first element, so the same unit also serves as the plain vector-to-scalar move.

Top module: `vec_elem_extract`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `res_valid` is 0 and `res_data` is 0.
- R2: `res_valid` is 1 in the cycle after a clock edge that saw `req_valid` high, and 0 after an edge that saw it low.
- R3: The width code on `sew_sel` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element i occupies bits [i*SEW +: SEW] of `vreg`, and element 0 sits at bit 0.
- R4: `elem_idx` is treated as an unsigned number across all XLEN bits. If it is greater than or equal to VLEN/SEW, the result is zero. This holds even when its low bits would name a valid element.
- R5: When SEW is smaller than XLEN, the element is placed in the low bits of `res_data` and every bit above it is 0.
- R6: When SEW equals XLEN, all bits of the element are returned unchanged. When SEW is larger than XLEN (possible only with other parameter values), the low XLEN bits are returned.
- R7: An index of 0 returns element 0 for every width code.
- R8: After a clock edge that saw `req_valid` low, `res_data` keeps the value it had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Extract request |
| vreg | input | VLEN | Contents of the vector register to read |
| sew_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64) |
| elem_idx | input | XLEN | Unsigned element index |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | XLEN | Extracted element, fitted to scalar width |

## Verification
Random register contents are read at every width code with the index set to 0, to the last valid element and to points in between. This separates a correct element placement from one that is shifted or uses the wrong width code. Indices equal to the element count, and large indices whose low bits look valid, show whether the range test uses the full index rather than wrapping. Back-to-back requests mixed with idle gaps check the one-cycle valid timing and that the result holds between requests. A register filled with all ones exposes any stray bits above a narrow element.

// File: rtl/vxt_pkg.sv
package vxt_pkg;
  typedef enum logic [1:0] {
    SEW_E8  = 2'd0,
    SEW_E16 = 2'd1,
    SEW_E32 = 2'd2,
    SEW_E64 = 2'd3
  } sew_code_t;

  localparam int NUM_SEW  = 4;
  localparam int MIN_SEW  = 8;
  localparam int MAX_SEW  = MIN_SEW << (NUM_SEW - 1);

  function automatic int sew_bits(input int code);
    return MIN_SEW << code;
  endfunction
endpackage

// File: rtl/vxt_range_check.sv
module vxt_range_check #(
  parameter int VLEN = 256,
  parameter int IDXW = 64
) (
  input  logic [1:0]      sew_sel,
  input  logic [IDXW-1:0] elem_idx,
  output logic            in_range
);
  import vxt_pkg::*;

  logic [NUM_SEW-1:0] fits;

  for (genvar k = 0; k < NUM_SEW; k++) begin : g_lim
    localparam int ELEMS = VLEN / sew_bits(k);
    assign fits[k] = (elem_idx < IDXW'(ELEMS));
  end

  assign in_range = fits[sew_sel];
endmodule

// File: rtl/vxt_lane_mux.sv
module vxt_lane_mux #(
  parameter int VLEN  = 256,
  parameter int MAXW  = 64,
  parameter int LOW_W = 5
) (
  input  logic [VLEN-1:0]  vreg,
  input  logic [1:0]       sew_sel,
  input  logic [LOW_W-1:0] idx_low,
  output logic [MAXW-1:0]  elem
);
  import vxt_pkg::*;

  logic [MAXW-1:0] lane [NUM_SEW];

  for (genvar k = 0; k < NUM_SEW; k++) begin : g_lane
    localparam int W     = sew_bits(k);
    localparam int ELEMS = VLEN / W;
    localparam int IB    = (ELEMS > 1) ? $clog2(ELEMS) : 1;
    logic [IB-1:0] sel;
    assign sel     = idx_low[IB-1:0];
    assign lane[k] = MAXW'(vreg[sel*W +: W]);
  end

  assign elem = lane[sew_sel];
endmodule

// File: rtl/vxt_width_fit.sv
module vxt_width_fit #(
  parameter int MAXW = 64,
  parameter int XLEN = 64
) (
  input  logic [MAXW-1:0] elem,
  output logic [XLEN-1:0] scalar
);
  if (XLEN >= MAXW) begin : g_extend
    assign scalar = XLEN'(elem);
  end else begin : g_truncate
    assign scalar = elem[XLEN-1:0];
  end
endmodule

// File: rtl/vec_elem_extract.sv
module vec_elem_extract #(
  parameter int VLEN = 256,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VLEN-1:0] vreg,
  input  logic [1:0]      sew_sel,
  input  logic [XLEN-1:0] elem_idx,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data
);
  import vxt_pkg::*;

  localparam int LOW_W = $clog2(VLEN / MIN_SEW);

  logic            idx_ok;
  logic [MAX_SEW-1:0] picked;
  logic [XLEN-1:0] fitted;

  vxt_range_check #(.VLEN(VLEN), .IDXW(XLEN)) u_range (
    .sew_sel  (sew_sel),
    .elem_idx (elem_idx),
    .in_range (idx_ok)
  );

  vxt_lane_mux #(.VLEN(VLEN), .MAXW(MAX_SEW), .LOW_W(LOW_W)) u_mux (
    .vreg    (vreg),
    .sew_sel (sew_sel),
    .idx_low (elem_idx[LOW_W-1:0]),
    .elem    (picked)
  );

  vxt_width_fit #(.MAXW(MAX_SEW), .XLEN(XLEN)) u_fit (
    .elem   (picked),
    .scalar (fitted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid)
        res_data <= idx_ok ? fitted : '0;
    end
  end
endmodule

// File: rtl/vec_elem_extract_chk.sv
module vec_elem_extract_chk #(
  parameter int VLEN = 256,
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VLEN-1:0] vreg,
  input logic [1:0]      sew_sel,
  input logic [XLEN-1:0] elem_idx,
  input logic            res_valid,
  input logic [XLEN-1:0] res_data
);
  logic [XLEN-1:0] count_lim;
  logic            unused_ok;
  assign count_lim = XLEN'(VLEN >> (3 + sew_sel));
  assign unused_ok = ^vreg;

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R2
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  // R4
  a_r4_out_of_range_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && elem_idx >= count_lim) |=> (res_data == '0));
  // R5
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sew_sel != 2'd3) |=> ((res_data >> (8 << $past(sew_sel))) == '0));
  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_data));
endmodule

bind vec_elem_extract vec_elem_extract_chk #(.VLEN(VLEN), .XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .vreg      (vreg),
  .sew_sel   (sew_sel),
  .elem_idx  (elem_idx),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/vec_elem_extract_test.sv
module vec_elem_extract_test;
  localparam int VLEN = 256;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [VLEN-1:0] vreg = '0;
  logic [1:0]      sew_sel = 2'd0;
  logic [XLEN-1:0] elem_idx = '0;
  logic            res_valid;
  logic [XLEN-1:0] res_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R8";

  logic            m_valid;
  logic [XLEN-1:0] m_data;
  string           m_tag;

  always #4 clk = ~clk;

  vec_elem_extract #(.VLEN(VLEN), .XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vreg(vreg),
    .sew_sel(sew_sel), .elem_idx(elem_idx),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [XLEN-1:0] ref_extract(logic [VLEN-1:0] v, int code, logic [XLEN-1:0] idx);
    int w = 8 << code;
    int n = VLEN / w;
    logic [XLEN-1:0] r = '0;
    if (idx >= XLEN'(n)) return '0;
    for (int b = 0; b < w; b++)
      if (b < XLEN) r[b] = v[int'(idx) * w + b];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_tag   <= "R1";
    end else if (req_valid) begin
      m_valid <= 1'b1;
      m_data  <= ref_extract(vreg, int'(sew_sel), elem_idx);
      m_tag   <= cur_tag;
    end else begin
      m_valid <= 1'b0;
      m_tag   <= "R8";
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      checks++;
      if (res_valid !== 1'b0 || res_data !== '0) begin
        failures++;
        $display("FAIL R1 reset: valid=%b data=%h expected valid=0 data=0", res_valid, res_data);
      end
    end else if (!done) begin
      checks++;
      if (res_valid !== m_valid || res_data !== m_data) begin
        failures++;
        $display("FAIL %s (R2 timing): valid=%b data=%h expected valid=%b data=%h",
                 m_tag, res_valid, res_data, m_valid, m_data);
      end
    end
  end

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(logic [VLEN-1:0] v, int code, logic [XLEN-1:0] idx, string tag);
    @(negedge clk);
    cur_tag   = tag;
    req_valid = 1'b1;
    vreg      = v;
    sew_sel   = 2'(code);
    elem_idx  = idx;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      vreg      = rand_vec();
      elem_idx  = XLEN'($urandom);
      cur_tag   = "R8";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R7: index zero at every width
    for (int c = 0; c < 4; c++) issue(rand_vec(), c, '0, "R7");
    idle(1);
    // R3, R5, R6: every element at every width
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < VLEN / (8 << c); i++)
        issue(rand_vec(), c, XLEN'(i), c == 3 ? "R6" : "R3");
      idle(2);
    end
    // R5: all-ones register, no stray upper bits
    for (int c = 0; c < 3; c++) issue({VLEN{1'b1}}, c, XLEN'(1), "R5");
    // R4: boundary and large indices
    for (int c = 0; c < 4; c++) begin
      issue(rand_vec(), c, XLEN'(VLEN / (8 << c)), "R4");
      issue(rand_vec(), c, XLEN'(VLEN / (8 << c)) - 1, "R3");
      issue(rand_vec(), c, {1'b1, {(XLEN-2){1'b0}}, 1'b1}, "R4");
      issue(rand_vec(), c, XLEN'(64'h100) | XLEN'(2), "R4");
      issue(rand_vec(), c, '1, "R4");
    end
    idle(3);
    // R2, R8: mixed traffic
    for (int k = 0; k < 200; k++) begin
      if ($urandom % 3 == 0) idle(1 + $urandom % 3);
      else issue(rand_vec(), $urandom % 4, XLEN'($urandom % 40), "R2");
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule